// File: doc/BRIEF.md
# Infrared Carrier Presence Demodulator

This block decides whether a modulated infrared carrier is present on a raw receive line and turns it into a clean baseband level. A programmable divider derives a receive tick from the reference clock, and the nominal carrier period is 16 such ticks. The block measures the spacing between consecutive rising edges of the synchronized input in receive ticks. It accepts a spacing only if it lies within a tolerance window around 16 ticks, and a 2-bit select sets the window's lower and upper bounds independently.

Two accepted spacings in a row drive the output to mark, and it stays there while accepted edges keep arriving. A spacing outside the window drops the output to space and makes that edge the new reference for measurement. So does a silence longer than the upper bound of the window. With demodulation switched off, the synchronized raw level goes straight to the output. The output feeds a downstream pulse-width timer.

Top module: `ir_carrier_demod`

## Requirements
- R1: A receive tick occurs once every (divider + 1) reference cycles while enabled; edge spacings are counted in these ticks.
- R2: A steady carrier whose rising edges are 16 ticks apart drives level_out to 1 (mark); level_out 0 means space.
- R3: The lower bound of the window is 16 − E ticks, with E = 4 when win_sel[0] = 1 and E = 3 otherwise; a shorter spacing is rejected.
- R4: The upper bound of the window is 16 + L ticks, with L = 4 when win_sel[1] = 1 and L = 3 otherwise; a longer spacing is rejected.
- R5: Mark is asserted only after two consecutive in-window spacings, which means three rising edges; two edges alone leave the output at space.
- R6: An out-of-window spacing returns the output to space and restarts the measurement from that edge.
- R7: If no rising edge arrives within 16 + L ticks of the last one, the output returns to space. An in-window carrier that has just stopped keeps mark for shorter gaps.
- R8: With demod_en = 0 and en = 1, level_out follows the synchronized raw_in level.
- R9: With en = 0, level_out is space and all measurement state is cleared.
- R10: After a synchronous reset, level_out is space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Receiver enable |
| demod_en | input | 1 | 1 selects the demodulated carrier, 0 selects raw passthrough |
| win_sel | input | 2 | Tolerance select: bit 0 widens the lower bound, bit 1 widens the upper bound |
| divider | input | DIV_W | Receive tick divider; tick period is divider + 1 cycles |
| raw_in | input | 1 | Raw asynchronous infrared input |
| level_out | output | 1 | Registered output level, 1 = mark |

## Verification
On every cycle, the assertions check the following:
- a disabled block drives space;
- passthrough mode copies the synchronized input;
- mark can only rise on the cycle after a detected edge;
- the tick counter never runs past the divider;
- the gap counter stays inside its cap.

The window bounds for each select code, the requirement for two consecutive edges, the timeout distance and the restart after a rejected edge all depend on edge timing across many cycles. Only the bench's directed carrier patterns can show those.

// File: rtl/ir_demod_pkg.sv
package ir_demod_pkg;
  typedef enum logic [1:0] {
    WIN_E3_L3 = 2'd0,
    WIN_E4_L3 = 2'd1,
    WIN_E3_L4 = 2'd2,
    WIN_E4_L4 = 2'd3
  } win_t;
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] divider,
  output logic             tick,
  output logic [DIV_W-1:0] cnt
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q >= divider);
  assign tick = en && wrap;
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt_q <= '0;
    else if (wrap)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ir_edge_sync.sv
module ir_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= raw_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] && !prev_q;
endmodule

// File: rtl/ir_carrier_track.sv
module ir_carrier_track
  import ir_demod_pkg::*;
#(
  parameter int NOM_TICKS = 16,
  parameter int TOL_SMALL = 3,
  parameter int TOL_LARGE = 4,
  parameter int GAP_W     = 5,
  parameter int GAP_CAP   = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             rise,
  input  win_t             win,
  output logic             mark,
  output logic [GAP_W-1:0] gap
);
  localparam logic [GAP_W-1:0] LO_NARROW = GAP_W'(NOM_TICKS - TOL_SMALL);
  localparam logic [GAP_W-1:0] LO_WIDE   = GAP_W'(NOM_TICKS - TOL_LARGE);
  localparam logic [GAP_W-1:0] HI_NARROW = GAP_W'(NOM_TICKS + TOL_SMALL);
  localparam logic [GAP_W-1:0] HI_WIDE   = GAP_W'(NOM_TICKS + TOL_LARGE);
  localparam logic [GAP_W-1:0] CAP       = GAP_W'(GAP_CAP);

  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] span;
  logic [GAP_W-1:0] lo_bound;
  logic [GAP_W-1:0] hi_bound;
  logic [1:0]       hits_q;
  logic             ref_q;
  logic             mark_q;
  logic             in_win;

  always_comb begin
    lo_bound = win[0] ? LO_WIDE : LO_NARROW;
    hi_bound = win[1] ? HI_WIDE : HI_NARROW;
    span     = gap_q + GAP_W'(tick);
    in_win   = (span >= lo_bound) && (span <= hi_bound);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      gap_q  <= '0;
      hits_q <= '0;
      ref_q  <= 1'b0;
      mark_q <= 1'b0;
    end else if (rise) begin
      gap_q <= '0;
      ref_q <= 1'b1;
      if (ref_q && in_win) begin
        hits_q <= (hits_q == 2'd2) ? 2'd2 : hits_q + 2'd1;
        mark_q <= (hits_q != 2'd0);
      end else begin
        hits_q <= '0;
        mark_q <= 1'b0;
      end
    end else if (tick) begin
      if (gap_q >= hi_bound) begin
        ref_q  <= 1'b0;
        hits_q <= '0;
        mark_q <= 1'b0;
      end
      if (gap_q < CAP) gap_q <= gap_q + 1'b1;
    end
  end

  assign mark = mark_q;
  assign gap  = gap_q;
endmodule

// File: rtl/ir_carrier_demod.sv
module ir_carrier_demod
  import ir_demod_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int NOM_TICKS   = 16,
  parameter int TOL_SMALL   = 3,
  parameter int TOL_LARGE   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             demod_en,
  input  logic [1:0]       win_sel,
  input  logic [DIV_W-1:0] divider,
  input  logic             raw_in,
  output logic             level_out
);
  localparam int GAP_CAP = NOM_TICKS + TOL_LARGE + 1;
  localparam int GAP_W   = $clog2(GAP_CAP + 2);

  logic             tick;
  logic [DIV_W-1:0] tick_cnt;
  logic             raw_sync;
  logic             rise;
  logic             mark;
  logic [GAP_W-1:0] gap;
  logic             level_q;

  ir_tick_gen #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst(rst), .en(en), .divider(divider),
    .tick(tick), .cnt(tick_cnt)
  );

  ir_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .raw_in(raw_in), .level(raw_sync), .rise(rise)
  );

  ir_carrier_track #(
    .NOM_TICKS(NOM_TICKS), .TOL_SMALL(TOL_SMALL), .TOL_LARGE(TOL_LARGE),
    .GAP_W(GAP_W), .GAP_CAP(GAP_CAP)
  ) track_i (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .rise(rise),
    .win(win_t'(win_sel)), .mark(mark), .gap(gap)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) level_q <= 1'b0;
    else            level_q <= demod_en ? mark : raw_sync;
  end

  assign level_out = level_q;
endmodule

// File: rtl/ir_carrier_demod_chk.sv
module ir_carrier_demod_chk #(
  parameter int DIV_W   = 16,
  parameter int GAP_W   = 5,
  parameter int GAP_CAP = 21
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             demod_en,
  input logic [DIV_W-1:0] divider,
  input logic [DIV_W-1:0] tick_cnt,
  input logic             raw_sync,
  input logic             rise,
  input logic             mark,
  input logic [GAP_W-1:0] gap,
  input logic             level_out
);
  // R9: disabled block drives space on the next cycle
  a_r9_space_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !level_out);

  // R8: passthrough copies the synchronized input
  a_r8_passthrough: assert property (@(posedge clk) disable iff (rst)
    (en && !demod_en) |=> (level_out == $past(raw_sync)));

  // R5: mark can only appear right after a detected edge
  a_r5_mark_after_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(mark) |-> $past(rise));

  // R1: the tick counter stays at or below a stable divider
  a_r1_tick_bound: assert property (@(posedge clk) disable iff (rst)
    (en && $stable(divider) && $past(en)) |-> (tick_cnt <= divider));

  // R7: gap counter is capped, so timeout has been reached before cap
  a_r7_gap_capped: assert property (@(posedge clk) disable iff (rst)
    gap <= GAP_W'(GAP_CAP));
endmodule

bind ir_carrier_demod ir_carrier_demod_chk #(
  .DIV_W(DIV_W), .GAP_W(GAP_W), .GAP_CAP(GAP_CAP)
) chk_i (
  .clk(clk), .rst(rst), .en(en), .demod_en(demod_en), .divider(divider),
  .tick_cnt(tick_cnt), .raw_sync(raw_sync), .rise(rise), .mark(mark),
  .gap(gap), .level_out(level_out)
);

// File: tb/ir_carrier_demod_tb_top.sv
module ir_carrier_demod_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        demod_en = 1'b1;
  logic [1:0]  win_sel = 2'd0;
  logic [15:0] divider = 16'd0;
  logic        raw_in = 1'b0;
  logic        level_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ir_carrier_demod dut_i (
    .clk(clk), .rst(rst), .en(en), .demod_en(demod_en), .win_sel(win_sel),
    .divider(divider), .raw_in(raw_in), .level_out(level_out)
  );

  task automatic check(input string req, input logic exp);
    n_checks++;
    if (level_out !== exp) begin
      n_fail++;
      $display("FAIL %s: level_out=%b expected=%b at %0t", req, level_out, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulses(input int period, input int n);
    for (int p = 0; p < n; p++) begin
      raw_in = 1'b1;
      wait_cyc(period / 2);
      raw_in = 1'b0;
      wait_cyc(period - period / 2);
    end
  endtask

  task automatic restart(input logic [1:0] w, input logic [15:0] d);
    en = 1'b0; raw_in = 1'b0;
    wait_cyc(4);
    win_sel = w; divider = d; demod_en = 1'b1; en = 1'b1;
    wait_cyc(2);
  endtask

  task automatic t_reset;
    wait_cyc(3);
    check("R10 reset space", 1'b0);
    rst = 1'b0;
    wait_cyc(2);
    check("R10 after release", 1'b0);
  endtask

  task automatic t_nominal;
    restart(2'd0, 16'd0);
    pulses(16, 6);
    check("R2 nominal carrier mark", 1'b1);
  endtask

  task automatic t_early;
    restart(2'd0, 16'd0);
    pulses(12, 8);
    check("R3 span 12 rejected code0", 1'b0);
    restart(2'd1, 16'd0);
    pulses(12, 8);
    check("R3 span 12 accepted code1", 1'b1);
    restart(2'd1, 16'd0);
    pulses(11, 8);
    check("R3 span 11 rejected code1", 1'b0);
  endtask

  task automatic t_late;
    restart(2'd0, 16'd0);
    pulses(20, 6);
    check("R4 span 20 rejected code0", 1'b0);
    restart(2'd2, 16'd0);
    pulses(20, 6);
    check("R4 span 20 accepted code2", 1'b1);
    restart(2'd3, 16'd0);
    pulses(21, 6);
    check("R4 span 21 rejected code3", 1'b0);
  endtask

  task automatic t_two_edges;
    restart(2'd0, 16'd0);
    pulses(16, 2);
    check("R5 two edges stay space", 1'b0);
    pulses(16, 1);
    check("R5 third edge gives mark", 1'b1);
  endtask

  task automatic t_restart;
    restart(2'd0, 16'd0);
    pulses(16, 5);
    check("R6 locked before bad edge", 1'b1);
    pulses(8, 2);
    check("R6 bad spacing gives space", 1'b0);
  endtask

  task automatic t_timeout;
    restart(2'd0, 16'd0);
    pulses(16, 6);
    check("R7 mark held inside window", 1'b1);
    wait_cyc(10);
    check("R7 timeout gives space", 1'b0);
  endtask

  task automatic t_divider;
    restart(2'd0, 16'd1);
    pulses(32, 6);
    check("R1 divider1 span 32 cycles mark", 1'b1);
    restart(2'd0, 16'd1);
    pulses(16, 10);
    check("R1 divider1 span 16 cycles space", 1'b0);
  endtask

  task automatic t_passthrough;
    restart(2'd0, 16'd0);
    demod_en = 1'b0;
    raw_in = 1'b1;
    wait_cyc(5);
    check("R8 passthrough high", 1'b1);
    raw_in = 1'b0;
    wait_cyc(5);
    check("R8 passthrough low", 1'b0);
    demod_en = 1'b1;
  endtask

  task automatic t_disable;
    restart(2'd0, 16'd0);
    pulses(16, 5);
    check("R9 locked before disable", 1'b1);
    en = 1'b0;
    wait_cyc(2);
    check("R9 disabled space", 1'b0);
    en = 1'b1;
    pulses(16, 2);
    check("R9 state cleared by disable", 1'b0);
  endtask

  initial begin
    t_reset();
    t_nominal();
    t_early();
    t_late();
    t_two_edges();
    t_restart();
    t_timeout();
    t_divider();
    t_passthrough();
    t_disable();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule